// File: doc/BRIEF.md
# FIFO Threshold Offset Controller

This block sits beside a FIFO's storage and pointer logic. It holds the two threshold offsets that drive the FIFO's programmable warning flags: `m`, the distance from full, and `n`, the distance from empty. It turns the FIFO's current word count into registered, active-low almost-full and almost-empty flags.

One strap input, sampled while master reset is held, picks both the power-up value of the offsets and the way they are loaded afterwards. In serial mode, the offsets are loaded one bit per write-clock edge through a pin that doubles as the first-word-fall-through select during master reset. In parallel mode, they are written in data-bus-wide pieces on the write clock. In both modes they can be read back, piece by piece, on the read clock. Partial reset restarts the access sequences but keeps everything that was configured.

Top module: `flagoff_top`

## Requirements
- R1: While `mrst_i` is high, `ld_i` low sets both offsets to DEF_LO (127) and selects parallel loading. `ld_i` high sets both offsets to DEF_HI (1023) and selects serial loading.
- R2: `fwft_o` takes the value of `fwft_sdi_i` at each write-clock edge while `mrst_i` is high. It holds that value through later serial traffic and through partial resets.
- R3: In serial mode, each write-clock edge with `sen_i` high stores `fwft_sdi_i` into the next offset bit. The first AW bits fill `n` from bit 0 upward, and the next AW bits fill `m` from bit 0 upward. Bits not yet reached keep their previous value.
- R4: After 2*AW serial bits have been stored, further serial bits change nothing until the next master or partial reset restarts the bit count.
- R5: In parallel mode, each write-clock edge with `ld_i` and `wen_i` high stores `din_i` as the next piece. The order is `n` low piece, `n` high piece, `m` low piece, `m` high piece, and then it repeats. A piece covers DW bits starting at bit piece*DW, and bits at or above AW are dropped. Serial strobes are ignored in parallel mode, and parallel writes are ignored in serial mode.
- R6: In either mode, each read-clock edge with `ld_i` and `ren_i` high loads `dout_o` with the next piece, in the same order as R5. Bits at or above AW read as 0. `dout_o` holds its value at all other times.
- R7: One write-clock edge after the count is applied, `paf_n_o` is low exactly when `count_i` > DEPTH - min(m, DEPTH).
- R8: One write-clock edge after the count is applied, `pae_n_o` is low exactly when `count_i` < min(n, DEPTH).
- R9: `prst_i` restarts the write sequence, the read sequence and the serial bit count, and clears `dout_o`. It keeps both offsets, the loading mode and `fwft_o`.
- R10: Master reset clears `dout_o`, forces `paf_n_o` high and `pae_n_o` low, and restarts all sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| mrst_i | input | 1 | Master reset, synchronous, active high |
| prst_i | input | 1 | Partial reset, synchronous, active high |
| ld_i | input | 1 | Strap during master reset, offset access select afterwards |
| wen_i | input | 1 | Write enable |
| ren_i | input | 1 | Read enable |
| sen_i | input | 1 | Serial bit strobe |
| fwft_sdi_i | input | 1 | Fall-through select during master reset, serial data afterwards |
| din_i | input | DW | Parallel offset piece in |
| count_i | input | CW | FIFO word count |
| dout_o | output | DW | Offset piece read back |
| paf_n_o | output | 1 | Almost-full flag, active low |
| pae_n_o | output | 1 | Almost-empty flag, active low |
| fwft_o | output | 1 | Latched fall-through selection |

## Verification
The bench loads a high offset piece whose top bits fall above the register width. A design that kept those bits would read them back, or would compare against an unclamped offset. Offsets above DEPTH are then placed exactly at the clamp edge, where a missing clamp moves the almost-empty threshold. The bench also sends extra serial bits after the last offset bit, which a design without saturation would wrap into `n`. Finally, it applies a partial reset in the middle of a parallel sequence, which catches a design that clears the offsets or fails to restart the sequence.

// File: rtl/flagoff_pkg.sv
package flagoff_pkg;

  typedef enum logic {
    OFF_EMPTY = 1'b0,
    OFF_FULL  = 1'b1
  } off_sel_e;

  // Which register an access slot addresses: empty offset first.
  function automatic off_sel_e seq_target(input int seq, input int pieces);
    return (seq >= pieces) ? OFF_FULL : OFF_EMPTY;
  endfunction

  // Piece index inside the addressed register, low piece first.
  function automatic int seq_piece(input int seq, input int pieces);
    return (seq >= pieces) ? seq - pieces : seq;
  endfunction

  // Next access slot; wraps after both registers are covered.
  function automatic int seq_next(input int seq, input int pieces);
    return (seq + 1 >= 2 * pieces) ? 0 : seq + 1;
  endfunction

endpackage

// File: rtl/flagoff_wr.sv
module flagoff_wr #(
  parameter int AW     = 16,
  parameter int DW     = 9,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic          clk_i,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic          ld_i,
  input  logic          wen_i,
  input  logic          sen_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] m_o,
  output logic [AW-1:0] n_o,
  output logic          sermode_o,
  output logic          fwft_o
);
  import flagoff_pkg::*;

  localparam int PCS   = (AW + DW - 1) / DW;
  localparam int SEQN  = 2 * PCS;
  localparam int QW    = (SEQN > 2) ? $clog2(SEQN) : 1;
  localparam int SBITS = 2 * AW;
  localparam int SCW   = $clog2(SBITS + 1);
  localparam logic [AW-1:0] DEF_LO_V = AW'(DEF_LO);
  localparam logic [AW-1:0] DEF_HI_V = AW'(DEF_HI);

  function automatic logic [AW-1:0] put_piece(input logic [AW-1:0] old, input int idx,
                                               input logic [DW-1:0] val);
    logic [AW-1:0] r;
    r = old;
    for (int b = 0; b < AW; b++)
      if (b / DW == idx) r[b] = val[b % DW];
    return r;
  endfunction

  function automatic logic [AW-1:0] put_bit(input logic [AW-1:0] old, input int pos,
                                             input logic v);
    logic [AW-1:0] r;
    r = old;
    r[pos] = v;
    return r;
  endfunction

  logic [QW-1:0]  wseq_q;
  logic [SCW-1:0] scnt_q;

  // Named events for the assertions.
  logic     wr_par, wr_ser, ser_full;
  off_sel_e par_tgt;
  int       par_idx;

  assign ser_full = (scnt_q == SCW'(SBITS));
  assign wr_par   = ld_i && wen_i && !sermode_o && !prst_i;
  assign wr_ser   = sen_i && sermode_o && !prst_i && !ser_full;
  assign par_tgt  = seq_target(int'(wseq_q), PCS);
  assign par_idx  = seq_piece(int'(wseq_q), PCS);

  always_ff @(posedge clk_i) begin
    if (mrst_i) begin
      m_o       <= ld_i ? DEF_HI_V : DEF_LO_V;
      n_o       <= ld_i ? DEF_HI_V : DEF_LO_V;
      sermode_o <= ld_i;
      fwft_o    <= sdi_i;
      scnt_q    <= '0;
      wseq_q    <= '0;
    end else if (prst_i) begin
      scnt_q <= '0;
      wseq_q <= '0;
    end else begin
      if (wr_par) begin
        if (par_tgt == OFF_FULL) m_o <= put_piece(m_o, par_idx, din_i);
        else                     n_o <= put_piece(n_o, par_idx, din_i);
        wseq_q <= QW'(seq_next(int'(wseq_q), PCS));
      end
      if (wr_ser) begin
        if (int'(scnt_q) < AW) n_o <= put_bit(n_o, int'(scnt_q), sdi_i);
        else                   m_o <= put_bit(m_o, int'(scnt_q) - AW, sdi_i);
        scnt_q <= scnt_q + 1'b1;
      end
    end
  end

  p_ser_saturate_r4: assert property (@(posedge clk_i) disable iff (mrst_i)
    (sermode_o && ser_full) |=> ($stable(m_o) && $stable(n_o)));

  p_par_ignores_serial_r5: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!sermode_o && !wr_par) |=> ($stable(m_o) && $stable(n_o)));

  p_prst_keeps_cfg_r9: assert property (@(posedge clk_i) disable iff (mrst_i)
    prst_i |=> ($stable(m_o) && $stable(n_o) && $stable(sermode_o) && $stable(fwft_o)));

  p_wseq_range_r5: assert property (@(posedge clk_i) disable iff (mrst_i)
    int'(wseq_q) < SEQN);

endmodule

// File: rtl/flagoff_rd.sv
module flagoff_rd #(
  parameter int AW = 16,
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic          ld_i,
  input  logic          ren_i,
  input  logic [AW-1:0] m_i,
  input  logic [AW-1:0] n_i,
  output logic [DW-1:0] dout_o
);
  import flagoff_pkg::*;

  localparam int PCS  = (AW + DW - 1) / DW;
  localparam int SEQN = 2 * PCS;
  localparam int QW   = (SEQN > 2) ? $clog2(SEQN) : 1;

  function automatic logic [DW-1:0] get_piece(input logic [AW-1:0] v, input int idx);
    logic [DW-1:0] r;
    r = '0;
    for (int b = 0; b < DW; b++)
      if (idx * DW + b < AW) r[b] = v[idx * DW + b];
    return r;
  endfunction

  logic [QW-1:0] rseq_q;
  logic          rd_hit;
  off_sel_e      rd_tgt;
  int            rd_idx;

  assign rd_hit = ld_i && ren_i && !prst_i;
  assign rd_tgt = seq_target(int'(rseq_q), PCS);
  assign rd_idx = seq_piece(int'(rseq_q), PCS);

  always_ff @(posedge clk_i) begin
    if (mrst_i || prst_i) begin
      rseq_q <= '0;
      dout_o <= '0;
    end else if (rd_hit) begin
      dout_o <= get_piece((rd_tgt == OFF_FULL) ? m_i : n_i, rd_idx);
      rseq_q <= QW'(seq_next(int'(rseq_q), PCS));
    end
  end

  p_dout_hold_r6: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!rd_hit && !prst_i) |=> $stable(dout_o));

  p_rseq_moves_r6: assert property (@(posedge clk_i) disable iff (mrst_i || prst_i)
    rd_hit |=> (rseq_q != $past(rseq_q)));

endmodule

// File: rtl/flagoff_flags.sv
module flagoff_flags #(
  parameter int AW    = 16,
  parameter int DEPTH = 50000,
  parameter int CW    = 16
) (
  input  logic          clk_i,
  input  logic          mrst_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] m_i,
  input  logic [AW-1:0] n_i,
  output logic          paf_n_o,
  output logic          pae_n_o
);

  function automatic int clamp_off(input logic [AW-1:0] o);
    return (int'(o) > DEPTH) ? DEPTH : int'(o);
  endfunction

  function automatic logic near_full(input int cnt, input logic [AW-1:0] m);
    return cnt > DEPTH - clamp_off(m);
  endfunction

  function automatic logic near_empty(input int cnt, input logic [AW-1:0] n);
    return cnt < clamp_off(n);
  endfunction

  logic hit_full, hit_empty;
  assign hit_full  = near_full(int'(count_i), m_i);
  assign hit_empty = near_empty(int'(count_i), n_i);

  always_ff @(posedge clk_i) begin
    if (mrst_i) begin
      paf_n_o <= 1'b1;
      pae_n_o <= 1'b0;
    end else begin
      paf_n_o <= !hit_full;
      pae_n_o <= !hit_empty;
    end
  end

  p_reset_flags_r10: assert property (@(posedge clk_i) disable iff (mrst_i)
    $past(mrst_i) |-> (paf_n_o && !pae_n_o));

  p_empty_not_full_r7: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!$past(mrst_i) && $past(count_i) == '0) |-> paf_n_o);

  p_depth_not_empty_r8: assert property (@(posedge clk_i) disable iff (mrst_i)
    (!$past(mrst_i) && int'($past(count_i)) >= DEPTH) |-> pae_n_o);

endmodule

// File: rtl/flagoff_top.sv
module flagoff_top #(
  parameter int AW     = 16,
  parameter int DW     = 9,
  parameter int DEPTH  = 50000,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic          ld_i,
  input  logic          wen_i,
  input  logic          ren_i,
  input  logic          sen_i,
  input  logic          fwft_sdi_i,
  input  logic [DW-1:0] din_i,
  input  logic [CW-1:0] count_i,
  output logic [DW-1:0] dout_o,
  output logic          paf_n_o,
  output logic          pae_n_o,
  output logic          fwft_o
);

  logic [AW-1:0] m_q, n_q;
  logic          sermode_q;

  flagoff_wr #(.AW(AW), .DW(DW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_wr (
    .clk_i(wclk_i), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .wen_i(wen_i), .sen_i(sen_i), .sdi_i(fwft_sdi_i), .din_i(din_i),
    .m_o(m_q), .n_o(n_q), .sermode_o(sermode_q), .fwft_o(fwft_o)
  );

  flagoff_rd #(.AW(AW), .DW(DW)) u_rd (
    .clk_i(rclk_i), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .ren_i(ren_i), .m_i(m_q), .n_i(n_q), .dout_o(dout_o)
  );

  flagoff_flags #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk_i(wclk_i), .mrst_i(mrst_i), .count_i(count_i),
    .m_i(m_q), .n_i(n_q), .paf_n_o(paf_n_o), .pae_n_o(pae_n_o)
  );

  p_serial_mode_strap_r1: assert property (@(posedge wclk_i)
    mrst_i |=> (sermode_q == $past(ld_i)));

endmodule

// File: tb/flagoff_top_tb_top.sv
module flagoff_top_tb_top;
  localparam int AW = 16, DW = 9, DEPTH = 50000;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, ld = 1'b0, wen = 1'b0, ren = 1'b0, sen = 1'b0;
  logic sdi = 1'b1;
  logic [DW-1:0] din = '0;
  logic [CW-1:0] count = '0;
  logic [DW-1:0] dout;
  logic paf_n, pae_n, fwft;

  int n_chk = 0, n_bad = 0;
  int em = 127, en = 127;
  int exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #10 clk = ~clk;

  flagoff_top dut_i (
    .wclk_i(clk), .rclk_i(clk), .mrst_i(mrst), .prst_i(prst), .ld_i(ld),
    .wen_i(wen), .ren_i(ren), .sen_i(sen), .fwft_sdi_i(sdi), .din_i(din),
    .count_i(count), .dout_o(dout), .paf_n_o(paf_n), .pae_n_o(pae_n), .fwft_o(fwft)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int piece(input int v, input int idx);
    return (v >> (idx * DW)) & 9'h1FF;
  endfunction

  function automatic int clampv(input int v);
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  // Monitor: compare each read-back piece against the scoreboard.
  always @(posedge clk) rd_seen <= ld && ren && !mrst && !prst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 actual=%0d expected=none", dout);
      end else begin
        check(tag_q.pop_front(), int'(dout), exp_q.pop_front());
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic do_mrst(input logic ldv, input logic sdiv);
    mrst = 1'b1; ld = ldv; sdi = sdiv;
    tick(); tick();
    mrst = 1'b0; ld = 1'b0; sdi = 1'b0;
    em = ldv ? 1023 : 127; en = em;
  endtask

  task automatic do_prst();
    prst = 1'b1; tick(); prst = 1'b0;
  endtask

  task automatic pwr(input int val);
    ld = 1'b1; wen = 1'b1; din = DW'(val);
    tick();
    ld = 1'b0; wen = 1'b0;
  endtask

  task automatic prd(input int exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    ld = 1'b1; ren = 1'b1;
    tick();
    ld = 1'b0; ren = 1'b0;
  endtask

  task automatic read_all(input string req);
    prd(piece(en, 0), req); prd(piece(en, 1), req);
    prd(piece(em, 0), req); prd(piece(em, 1), req);
    tick();
  endtask

  task automatic flag(input int cnt, input string req);
    count = CW'(cnt);
    tick();
    check({req, " paf_n"}, int'(paf_n), (cnt > DEPTH - clampv(em)) ? 0 : 1);
    check({req, " pae_n"}, int'(pae_n), (cnt < clampv(en)) ? 0 : 1);
  endtask

  task automatic ser(input int val, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sen = 1'b1; sdi = val[i];
      tick();
    end
    sen = 1'b0; sdi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R10: state while master reset is held
    tick(); tick();
    check("R10 dout", int'(dout), 0);
    check("R10 paf_n", int'(paf_n), 1);
    check("R10 pae_n", int'(pae_n), 0);
    do_mrst(1'b0, 1'b1);
    check("R2 fwft latched", int'(fwft), 1);

    // R1 defaults of 127 in parallel mode, R7/R8 thresholds
    flag(126, "R8"); flag(127, "R8");
    flag(49873, "R7"); flag(49874, "R7");
    read_all("R1");

    // R5 parallel write, top bits dropped; R8 clamp above DEPTH
    pwr(9'h034); pwr(9'h1FF); pwr(200); pwr(0);
    en = 16'hFE34; em = 200;
    read_all("R5");
    flag(49999, "R8 clamp"); flag(50000, "R8 clamp");
    flag(49800, "R7"); flag(49801, "R7");

    // R5: serial strobes ignored in parallel mode
    ser(32'h0000_0000, 20);
    check("R2 fwft hold", int'(fwft), 1);
    read_all("R5 serial ignored");

    // R9: partial reset mid-sequence keeps offsets, restarts sequence
    pwr(5);
    en = (en & 16'hFE00) | 5;
    prd(piece(en, 0), "R9");
    do_prst();
    check("R9 dout cleared", int'(dout), 0);
    check("R9 fwft kept", int'(fwft), 1);
    read_all("R9");

    // R1 serial defaults of 1023, R2 fwft low
    do_mrst(1'b1, 1'b0);
    check("R2 fwft relatched", int'(fwft), 0);
    read_all("R1 serial");

    // R5: parallel writes ignored in serial mode
    pwr(0); pwr(0); pwr(0); pwr(0);
    read_all("R5 par ignored");

    // R3: serial fill of n first, m keeps default
    ser(300, 16); en = 300;
    read_all("R3");
    ser(1000, 16); em = 1000;
    // R4: bits beyond the last are ignored
    ser(32'hFFFF_FFFF, 5);
    read_all("R4");
    flag(299, "R8"); flag(300, "R8");
    flag(49000, "R7"); flag(49001, "R7");

    // R9: partial reset restarts the serial bit count
    do_prst();
    ser(7, 16); en = 7;
    read_all("R9 serial restart");
    flag(6, "R8"); flag(7, "R8");

    tick();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule